// File: doc/BRIEF.md
# Ethernet Controller Host Register Block

This block is the host-side register window of an Ethernet controller. The host sees three word locations at byte offsets: an 8-bit pointer, a data port for the control/status register bank and a data port for the configuration register bank. Each data port reaches whichever register the pointer currently selects. Host reads return their data one clock after the read strobe.

The block implements the main control word in full. This covers the start, stop and initialise commands, seven event flags that are set from the DMA side and cleared by writing one, a sticky interrupt enable, an interrupt flag derived from a separate mask register, and receiver-on and transmitter-on bits derived from the mode register. It also decodes the ring-size register into ring lengths, presents the management-interface PHY and register address to an external register file, and returns that file's data.

The DMA engines receive single-cycle initialise, start and stop requests. On the stop request they clear their ring positions. They also receive the on-bits and the ring lengths, and a level interrupt goes to the host.

Top module: `nic_regport`

## Requirements
- R1: Byte offset 0x14 is the pointer; a write keeps the low 8 bits of the write data. Offset 0x10 reaches control/status register number `pointer`, and offset 0x1C reaches configuration register number `pointer`. Read data appears on `host_rdata` in the cycle after `host_rd` and holds until the next read.
- R2: A write to control register 0 with bit 2 set leaves register 0 reading exactly 0x0004 and ignores every other bit of that write. It also drops any event arriving in the same cycle and pulses `stop_pulse` for one cycle.
- R3: Register 0 bits 14..8 are event flags, and `ev_set[i]` sets bit 8+i (bit 14 is the timeout flag and bit 8 is the init-done flag). A write with a 1 in one of these positions clears that flag, and a 0 leaves it alone. If a set and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: Writing 1 to register 0 bit 6 sets the interrupt enable. Only a stop write clears it.
- R5: Writing 1 to register 0 bit 0 sets bit 0, clears the stop bit and pulses `init_req`. Writing 1 to bit 1 sets bit 1, clears the stop bit and pulses `start_pulse`.
- R6: Register 0 bit 5 and `rx_on` equal bit 1 AND NOT mode register (register 15) bit 0. Register 0 bit 4 and `tx_on` equal bit 1 AND NOT mode bit 1.
- R7: Register 0 bit 7 is 1 exactly when some event flag at bit k (14..8) has bit k of register 3 set. `irq` is high while both bit 7 and bit 6 are set.
- R8: Register 6 keeps write bits 11:8 (receive log2 length) and 15:12 (transmit log2 length) and reads back only those bits. Each ring length output is 2 raised to the stored value, capped at 512.
- R9: Configuration register 9 always reads 1 and ignores writes. `mii_phy` is configuration register 33 bits 9:5, and `mii_reg` is bits 4:0 of the same register. Reading configuration register 34 returns `mii_rdata`, and writes to register 34 change nothing.
- R10: Control register 88 reads 0x02623003 while `fast_if` is 1 and 0 otherwise, and ignores writes.
- R11: Every other register in both banks is 32-bit read/write storage. After reset, everything reads 0 except register 0, which reads 0x0004.
- R12: Host accesses at any other byte offset read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| fast_if | input | 1 | Interface is the 100 Mb/s type |
| ev_set | input | 7 | Event set strobes from DMA, bit i to flag 8+i |
| mii_rdata | input | 16 | Data of the addressed management register |
| init_req | output | 1 | One-cycle initialise request |
| start_pulse | output | 1 | One-cycle start request |
| stop_pulse | output | 1 | One-cycle stop request; ring positions clear |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| irq | output | 1 | Level interrupt to host |
| rx_ring_len | output | 10 | Receive ring length in descriptors |
| tx_ring_len | output | 10 | Transmit ring length in descriptors |
| mii_phy | output | 5 | Management PHY address |
| mii_reg | output | 5 | Management register address |

## Verification
Most internal faults reach a port within one clock. A wrong control-word bit changes `rx_on`, `tx_on` or `irq` in the cycle after the write that caused it, and it also shows in the next read of register 0. A wrong event flag or mask bit appears on `irq` as soon as the interrupt enable is set. A corrupted pointer sends the next data-port access to the wrong register, so that read returns the wrong value. The reference model is checked against every output on every clock, which means a divergence is reported in the cycle it first becomes visible.

// File: rtl/nic_regs_pkg.sv
// Shared constants for the NIC host register block.
// Assumes a 32-bit host data path and byte offsets on a 5-bit address.
package nic_regs_pkg;
    localparam int EV_N   = 7;   // number of event flags
    localparam int EV_LSB = 8;   // bit position of the lowest event flag

    // control word bit positions
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_IENA = 6;

    // register numbers in the control/status bank
    localparam int IDX_CTL  = 0;
    localparam int IDX_MASK = 3;
    localparam int IDX_RING = 6;
    localparam int IDX_MODE = 15;
    localparam int IDX_ID   = 88;

    // register numbers in the configuration bank
    localparam int BIDX_FIXED  = 9;
    localparam int BIDX_MIIADR = 33;
    localparam int BIDX_MIIDAT = 34;

    localparam logic [31:0] CHIP_ID = 32'h0262_3003;

    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_PTR,
        PORT_CSR,
        PORT_BCR
    } port_e;

    // Map a host byte offset to the port it selects.
    function automatic port_e decode_port(input logic [4:0] off);
        case (off)
            5'h10:   decode_port = PORT_CSR;
            5'h14:   decode_port = PORT_PTR;
            5'h1C:   decode_port = PORT_BCR;
            default: decode_port = PORT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/nic_ctl_status.sv
// Main control/status word: commands, write-one-to-clear events,
// interrupt enable, derived interrupt flag and on-bits.
// Assumes wr is a single-cycle strobe for a write to register 0.
module nic_ctl_status
    import nic_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            w_init,
    input  logic            w_strt,
    input  logic            w_stop,
    input  logic            w_iena,
    input  logic [EV_N-1:0] w_clr,
    input  logic [EV_N-1:0] ev_set,
    input  logic [EV_N-1:0] ev_mask,
    input  logic [1:0]      mode_dis,
    output logic [15:0]     status,
    output logic            init_req,
    output logic            start_pulse,
    output logic            stop_pulse,
    output logic            rx_on,
    output logic            tx_on,
    output logic            irq
);
    logic [EV_N-1:0] ev_q;
    logic iena_q, init_q, strt_q, stop_q;
    logic intr;

    // Command, enable and event state; stop has top priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q        <= '0;
            iena_q      <= 1'b0;
            init_q      <= 1'b0;
            strt_q      <= 1'b0;
            stop_q      <= 1'b1;
            init_req    <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            init_req    <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            if (wr && w_stop) begin
                ev_q       <= '0;
                iena_q     <= 1'b0;
                init_q     <= 1'b0;
                strt_q     <= 1'b0;
                stop_q     <= 1'b1;
                stop_pulse <= 1'b1;
            end else begin
                ev_q <= (ev_q & ~(wr ? w_clr : '0)) | ev_set;
                if (wr && w_iena) iena_q <= 1'b1;
                if (wr && w_init) begin
                    init_q   <= 1'b1;
                    stop_q   <= 1'b0;
                    init_req <= 1'b1;
                end
                if (wr && w_strt) begin
                    strt_q      <= 1'b1;
                    stop_q      <= 1'b0;
                    start_pulse <= 1'b1;
                end
            end
        end
    end

    // Derived flag, on-bits and the assembled read value.
    always_comb begin
        intr   = |(ev_q & ev_mask);
        rx_on  = strt_q & ~mode_dis[0];
        tx_on  = strt_q & ~mode_dis[1];
        irq    = intr & iena_q;
        status = {1'b0, ev_q, intr, iena_q, rx_on, tx_on, 1'b0, stop_q, strt_q, init_q};
    end

    p_stop_wipes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && w_stop) |=> (status == 16'h0004 && stop_pulse));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !w_stop) |=> ((ev_q & $past(w_clr & ~ev_set)) == '0));

    p_iena_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iena_q && !(wr && w_stop)) |=> iena_q);

    p_init_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !w_stop && w_init) |=> (init_req && init_q && !stop_q));

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !w_stop && w_strt) |=> (start_pulse && strt_q && !stop_q));
endmodule

// File: rtl/nic_ring_size.sv
// Ring-size register: two log2 fields decoded to capped lengths.
// Assumes wdata carries write bits 15:8 of the host word.
module nic_ring_size #(
    parameter int L2_W    = 4,
    parameter int CAP_LOG = 9,
    localparam int LEN_W  = CAP_LOG + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [2*L2_W-1:0]         wdata,
    output logic [2*L2_W-1:0]         rd_val,
    output logic [1:0][LEN_W-1:0]     ring_len
);
    logic [1:0][L2_W-1:0] l2_q;

    // Hold the receive (index 0) and transmit (index 1) log2 sizes.
    always_ff @(posedge clk) begin
        if (!rst_n) l2_q <= '0;
        else if (wr) l2_q <= wdata;
    end

    assign rd_val = l2_q;

    for (genvar g = 0; g < 2; g++) begin : g_ring
        // Decode one ring's length, capped at 2**CAP_LOG.
        always_comb begin
            if (int'(l2_q[g]) >= CAP_LOG) ring_len[g] = LEN_W'(1) << CAP_LOG;
            else                          ring_len[g] = LEN_W'(1) << l2_q[g];
        end

        p_ring_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wdata[g*L2_W +: L2_W] == '0) |=> (ring_len[g] == LEN_W'(1)));
    end
endmodule

// File: rtl/nic_plain_store.sv
// Generic read/write register storage, one write and one read port.
// Assumes reads are combinational and writes take effect next cycle.
module nic_plain_store #(
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, else store the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nic_regport.sv
// Top of the NIC host register block: pointer, two indirect data ports,
// dedicated registers and plain storage for the rest.
// Assumes single-cycle host strobes; read data is registered.
module nic_regport
    import nic_regs_pkg::*;
#(
    parameter int RAP_W   = 8,
    parameter int DW      = 32,
    parameter int CAP_LOG = 9,
    localparam int LEN_W  = CAP_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [4:0]       host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic             fast_if,
    input  logic [EV_N-1:0]  ev_set,
    input  logic [15:0]      mii_rdata,
    output logic             init_req,
    output logic             start_pulse,
    output logic             stop_pulse,
    output logic             rx_on,
    output logic             tx_on,
    output logic             irq,
    output logic [LEN_W-1:0] rx_ring_len,
    output logic [LEN_W-1:0] tx_ring_len,
    output logic [4:0]       mii_phy,
    output logic [4:0]       mii_reg
);
    port_e             port;
    logic [RAP_W-1:0]  rap_q;
    logic [DW-1:0]     mask_q, mode_q, miiadr_q;
    logic [DW-1:0]     csr_rd, bcr_rd, rd_mux;
    logic [15:0]       status;
    logic [7:0]        ring_rd;
    logic [1:0][LEN_W-1:0] ring_len;
    logic              wr_csr, wr_bcr;
    logic              sel_ctl, sel_mask, sel_ring, sel_mode, sel_id;
    logic              sel_fixed, sel_miiadr, sel_miidat;

    // Decode the port and the register the pointer selects.
    always_comb begin
        port       = decode_port(host_addr);
        wr_csr     = host_wr && port == PORT_CSR;
        wr_bcr     = host_wr && port == PORT_BCR;
        sel_ctl    = rap_q == RAP_W'(IDX_CTL);
        sel_mask   = rap_q == RAP_W'(IDX_MASK);
        sel_ring   = rap_q == RAP_W'(IDX_RING);
        sel_mode   = rap_q == RAP_W'(IDX_MODE);
        sel_id     = rap_q == RAP_W'(IDX_ID);
        sel_fixed  = rap_q == RAP_W'(BIDX_FIXED);
        sel_miiadr = rap_q == RAP_W'(BIDX_MIIADR);
        sel_miidat = rap_q == RAP_W'(BIDX_MIIDAT);
    end

    // Pointer and the dedicated full-width registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rap_q    <= '0;
            mask_q   <= '0;
            mode_q   <= '0;
            miiadr_q <= '0;
        end else begin
            if (host_wr && port == PORT_PTR) rap_q <= host_wdata[RAP_W-1:0];
            if (wr_csr && sel_mask) mask_q <= host_wdata;
            if (wr_csr && sel_mode) mode_q <= host_wdata;
            if (wr_bcr && sel_miiadr) miiadr_q <= host_wdata;
        end
    end

    nic_ctl_status u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_csr && sel_ctl),
        .w_init      (host_wdata[B_INIT]),
        .w_strt      (host_wdata[B_STRT]),
        .w_stop      (host_wdata[B_STOP]),
        .w_iena      (host_wdata[B_IENA]),
        .w_clr       (host_wdata[EV_LSB +: EV_N]),
        .ev_set      (ev_set),
        .ev_mask     (mask_q[EV_LSB +: EV_N]),
        .mode_dis    (mode_q[1:0]),
        .status      (status),
        .init_req    (init_req),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .rx_on       (rx_on),
        .tx_on       (tx_on),
        .irq         (irq)
    );

    nic_ring_size #(.L2_W(4), .CAP_LOG(CAP_LOG)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_csr && sel_ring),
        .wdata    (host_wdata[15:8]),
        .rd_val   (ring_rd),
        .ring_len (ring_len)
    );

    nic_plain_store #(.AW(RAP_W), .DW(DW)) u_csr_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_csr && !(sel_ctl || sel_mask || sel_ring || sel_mode || sel_id)),
        .waddr (rap_q),
        .wdata (host_wdata),
        .raddr (rap_q),
        .rdata (csr_rd)
    );

    nic_plain_store #(.AW(RAP_W), .DW(DW)) u_bcr_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_bcr && !(sel_fixed || sel_miiadr || sel_miidat)),
        .waddr (rap_q),
        .wdata (host_wdata),
        .raddr (rap_q),
        .rdata (bcr_rd)
    );

    assign rx_ring_len = ring_len[0];
    assign tx_ring_len = ring_len[1];
    assign mii_phy     = miiadr_q[9:5];
    assign mii_reg     = miiadr_q[4:0];

    // Select the value a read of the current port and pointer returns.
    always_comb begin
        rd_mux = '0;
        case (port)
            PORT_PTR: rd_mux = DW'(rap_q);
            PORT_CSR: begin
                if      (sel_ctl)  rd_mux = DW'(status);
                else if (sel_mask) rd_mux = mask_q;
                else if (sel_ring) rd_mux = DW'({ring_rd, 8'h00});
                else if (sel_mode) rd_mux = mode_q;
                else if (sel_id)   rd_mux = fast_if ? DW'(CHIP_ID) : '0;
                else               rd_mux = csr_rd;
            end
            PORT_BCR: begin
                if      (sel_fixed)  rd_mux = DW'(1);
                else if (sel_miiadr) rd_mux = miiadr_q;
                else if (sel_miidat) rd_mux = DW'(mii_rdata);
                else                 rd_mux = bcr_rd;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && port == PORT_PTR) |=> $stable(rap_q));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(host_wr || (|ev_set)));

    p_id_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && port == PORT_CSR && sel_id) |=>
            (host_rdata == ($past(fast_if) ? DW'(CHIP_ID) : '0)));
endmodule

// File: tb/nic_regport_test.sv
module nic_regport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fast_if = 1'b0;
    logic [6:0]  ev_set = '0;
    logic [15:0] mii_rdata;
    logic        init_req, start_pulse, stop_pulse, rx_on, tx_on, irq;
    logic [9:0]  rx_ring_len, tx_ring_len;
    logic [4:0]  mii_phy, mii_reg;

    int checks = 0;
    int fails = 0;
    bit running = 1'b0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    assign mii_rdata = {5'b10110, mii_phy, 1'b0, mii_reg};

    nic_regport uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fast_if(fast_if), .ev_set(ev_set), .mii_rdata(mii_rdata),
        .init_req(init_req), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .rx_on(rx_on), .tx_on(tx_on), .irq(irq),
        .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len),
        .mii_phy(mii_phy), .mii_reg(mii_reg)
    );

    // reference model state
    logic [6:0]  m_ev;
    logic        m_iena, m_init, m_strt, m_stop;
    logic [31:0] m_mask, m_mode, m_b33, m_r6;
    logic [7:0]  m_rap;
    logic [31:0] m_csr [256];
    logic [31:0] m_bcr [256];
    logic [31:0] e_rdata;
    logic        e_init, e_start, e_stop;

    function automatic logic [31:0] m_status();
        logic intr, rxo, txo;
        intr = (m_ev & m_mask[14:8]) != 0;
        rxo = m_strt && !m_mode[0];
        txo = m_strt && !m_mode[1];
        return {16'h0, 1'b0, m_ev, intr, m_iena, rxo, txo, 1'b0, m_stop, m_strt, m_init};
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a == 5'h14) return {24'h0, m_rap};
        if (a == 5'h10) begin
            if (m_rap == 0)  return m_status();
            if (m_rap == 3)  return m_mask;
            if (m_rap == 6)  return m_r6 & 32'hFF00;
            if (m_rap == 15) return m_mode;
            if (m_rap == 88) return fast_if ? 32'h0262_3003 : 32'h0;
            return m_csr[m_rap];
        end
        if (a == 5'h1C) begin
            if (m_rap == 9)  return 32'h1;
            if (m_rap == 33) return m_b33;
            if (m_rap == 34) return {16'h0, 5'b10110, m_b33[9:5], 1'b0, m_b33[4:0]};
            return m_bcr[m_rap];
        end
        return 32'h0;
    endfunction

    function automatic int exp_len(input logic [3:0] l2);
        return (l2 >= 9) ? 512 : (1 << l2);
    endfunction

    // model update on each rising edge from the stable inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ev = 0; m_iena = 0; m_init = 0; m_strt = 0; m_stop = 1;
            m_mask = 0; m_mode = 0; m_b33 = 0; m_r6 = 0; m_rap = 0;
            for (int i = 0; i < 256; i++) begin m_csr[i] = 0; m_bcr[i] = 0; end
            e_rdata = 0; e_init = 0; e_start = 0; e_stop = 0;
        end else begin
            logic [6:0] clr;
            bit stopped;
            clr = 0; stopped = 0;
            if (host_rd) e_rdata = m_read(host_addr);
            e_init = 0; e_start = 0; e_stop = 0;
            if (host_wr && host_addr == 5'h14) m_rap = host_wdata[7:0];
            if (host_wr && host_addr == 5'h10) begin
                if (m_rap == 0) begin
                    if (host_wdata[2]) begin
                        m_ev = 0; m_iena = 0; m_init = 0; m_strt = 0; m_stop = 1;
                        e_stop = 1; stopped = 1;
                    end else begin
                        clr = host_wdata[14:8];
                        if (host_wdata[6]) m_iena = 1;
                        if (host_wdata[0]) begin m_init = 1; m_stop = 0; e_init = 1; end
                        if (host_wdata[1]) begin m_strt = 1; m_stop = 0; e_start = 1; end
                    end
                end else if (m_rap == 3) m_mask = host_wdata;
                else if (m_rap == 6) m_r6 = host_wdata;
                else if (m_rap == 15) m_mode = host_wdata;
                else if (m_rap != 88) m_csr[m_rap] = host_wdata;
            end
            if (host_wr && host_addr == 5'h1C) begin
                if (m_rap == 33) m_b33 = host_wdata;
                else if (m_rap != 9 && m_rap != 34) m_bcr[m_rap] = host_wdata;
            end
            if (!stopped) m_ev = (m_ev & ~clr) | ev_set;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            logic [31:0] st;
            st = m_status();
            chk("R7", "irq", irq, st[7] & st[6]);
            chk("R6", "rx_on", rx_on, st[5]);
            chk("R6", "tx_on", tx_on, st[4]);
            chk("R5", "init_req", init_req, e_init);
            chk("R5", "start_pulse", start_pulse, e_start);
            chk("R2", "stop_pulse", stop_pulse, e_stop);
            chk("R8", "rx_ring_len", rx_ring_len, exp_len(m_r6[11:8]));
            chk("R8", "tx_ring_len", tx_ring_len, exp_len(m_r6[15:12]));
            chk("R9", "mii_phy", mii_phy, m_b33[9:5]);
            chk("R9", "mii_reg", mii_reg, m_b33[4:0]);
            chk(cur_req, "host_rdata", host_rdata, e_rdata);
        end
    end

    task automatic cyc(input bit w, input bit r, input logic [4:0] a,
                       input logic [31:0] d, input logic [6:0] ev);
        @(negedge clk);
        host_wr = w; host_rd = r; host_addr = a; host_wdata = d; ev_set = ev;
        @(negedge clk);
        host_wr = 0; host_rd = 0; ev_set = 0;
    endtask

    task automatic ptr(input logic [7:0] n);
        cyc(1, 0, 5'h14, {24'h0, n}, 0);
    endtask

    task automatic csr_wr(input logic [7:0] n, input logic [31:0] d);
        ptr(n); cyc(1, 0, 5'h10, d, 0);
    endtask

    task automatic bcr_wr(input logic [7:0] n, input logic [31:0] d);
        ptr(n); cyc(1, 0, 5'h1C, d, 0);
    endtask

    // read one location and compare against a hand-computed value
    task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        cyc(0, 1, a, 0, 0);
        chk(tag, "read", host_rdata, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R11 reset state
        cur_req = "R11";
        expect_rd(5'h10, 32'h0000_0004, "R11");
        expect_rd(5'h14, 32'h0, "R1");

        // R1 pointer width and readback
        cur_req = "R1";
        cyc(1, 0, 5'h14, 32'h0000_01A5, 0);
        expect_rd(5'h14, 32'h0000_00A5, "R1");

        // R11 plain storage in both banks
        cur_req = "R11";
        csr_wr(5, 32'hDEAD_BEEF);
        expect_rd(5'h10, 32'hDEAD_BEEF, "R11");
        bcr_wr(20, 32'h1234_5678);
        expect_rd(5'h1C, 32'h1234_5678, "R11");
        csr_wr(255, 32'hCAFE_0001);
        expect_rd(5'h10, 32'hCAFE_0001, "R11");

        // R10 chip identifier
        cur_req = "R10";
        fast_if = 1;
        csr_wr(88, 32'hFFFF_FFFF);
        expect_rd(5'h10, 32'h0262_3003, "R10");
        fast_if = 0;
        expect_rd(5'h10, 32'h0, "R10");

        // R5 init and start
        cur_req = "R5";
        csr_wr(0, 32'h0000_0001);
        expect_rd(5'h10, 32'h0000_0001, "R5");
        cyc(1, 0, 5'h10, 32'h0000_0002, 0);
        expect_rd(5'h10, 32'h0000_0033, "R5");

        // R6 on-bits follow the mode disables
        cur_req = "R6";
        csr_wr(15, 32'h1);
        ptr(0); expect_rd(5'h10, 32'h0000_0013, "R6");
        csr_wr(15, 32'h2);
        ptr(0); expect_rd(5'h10, 32'h0000_0023, "R6");
        csr_wr(15, 32'h0);

        // R3 events set, write-one-to-clear, zero leaves, set wins
        cur_req = "R3";
        ptr(0);
        cyc(0, 0, 5'h0, 0, 7'h7F);
        expect_rd(5'h10, 32'h0000_7F33, "R3");
        cyc(1, 0, 5'h10, 32'h0000_0500, 0);
        expect_rd(5'h10, 32'h0000_7A33, "R3");
        cyc(1, 0, 5'h10, 32'h0000_0000, 0);
        expect_rd(5'h10, 32'h0000_7A33, "R3");
        cyc(1, 0, 5'h10, 32'h0000_7A00, 7'h02);
        expect_rd(5'h10, 32'h0000_0233, "R3");

        // R7 and R4 interrupt flag, enable and output
        cur_req = "R7";
        csr_wr(3, 32'h0000_0200);
        ptr(0); expect_rd(5'h10, 32'h0000_02B3, "R7");
        cur_req = "R4";
        cyc(1, 0, 5'h10, 32'h0000_0040, 0);
        chk("R4", "irq", irq, 1);
        cyc(1, 0, 5'h10, 32'h0000_0000, 0);
        expect_rd(5'h10, 32'h0000_02F3, "R4");
        cur_req = "R7";
        cyc(1, 0, 5'h10, 32'h0000_0200, 0);
        chk("R7", "irq", irq, 0);
        cyc(0, 0, 5'h0, 0, 7'h01);
        chk("R7", "irq masked", irq, 0);

        // R2 stop overrides everything in the same write
        cur_req = "R2";
        cyc(1, 0, 5'h10, 32'h0000_7F47, 7'h7F);
        expect_rd(5'h10, 32'h0000_0004, "R2");
        chk("R2", "rx_on", rx_on, 0);

        // R8 ring sizes
        cur_req = "R8";
        csr_wr(6, 32'h0000_3400);
        chk("R8", "rx len", rx_ring_len, 16);
        chk("R8", "tx len", tx_ring_len, 8);
        csr_wr(6, 32'h0000_FA00);
        chk("R8", "rx cap", rx_ring_len, 512);
        chk("R8", "tx cap", tx_ring_len, 512);
        csr_wr(6, 32'h0001_23FF);
        expect_rd(5'h10, 32'h0000_2300, "R8");

        // R9 fixed and management registers
        cur_req = "R9";
        bcr_wr(9, 32'h0);
        expect_rd(5'h1C, 32'h1, "R9");
        bcr_wr(33, 32'h0000_00A7);
        chk("R9", "mii_phy", mii_phy, 5);
        ptr(34);
        expect_rd(5'h1C, 32'h0000_B147, "R9");
        cyc(1, 0, 5'h1C, 32'hFFFF_FFFF, 0);
        expect_rd(5'h1C, 32'h0000_B147, "R9");

        // R12 other offsets
        cur_req = "R12";
        cyc(1, 0, 5'h08, 32'h0000_0055, 0);
        expect_rd(5'h04, 32'h0, "R12");
        expect_rd(5'h14, 32'h0000_0022, "R12");

        repeat (3) @(negedge clk);
        running = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule